// File: doc/BRIEF.md
# Edge-Timestamp Pulse Delay Line

This block copies a digital input waveform to an output after a fixed, programmable number of timebase ticks. A counter runs freely and is never cleared. Every transition of the synchronized input, rising or falling, is stamped with the current count. The programmed delay is added to that stamp modulo the counter width. The resulting target time is pushed, together with the new level, into a small circular queue. A compare stage watches the entry at the head of the queue. When the counter reaches that entry's target, it drives the output to the stored level and retires the entry. Several transitions can therefore be in flight within one delay window.

The counter moves on a tick-enable strobe, so the delay unit is set by whatever cadence the surrounding chip supplies, for example one tick per microsecond. Input transitions that arrive while the queue is full are discarded, and a sticky flag records the loss. Each time the counter rolls over while nothing is pending, the output is realigned to the current input level. This repairs any mismatch left by a lost transition.

Top module: `pulseDelayLine`

## Requirements
- R1: After reset, pulseOut is 0, queueEmpty is 1, queueFull is 0 and overflow is 0.
- R2: The timebase counter advances by one only in cycles where tickEn is 1. With tickEn held at 0, a captured transition never reaches the output.
- R3: With tickEn high every cycle and a constant delayVal d in 1..2^CNT_W-1, pulseOut after clock edge n equals pulseIn as sampled at clock edge n-d-2. The two extra cycles are the input synchronizer. This holds for both rising and falling transitions, and across counter rollover, because target = capture count + d with the carry discarded.
- R4: The queue holds up to DEPTH pending transitions. queueEmpty is 1 exactly when none are pending, and queueFull is 1 exactly when DEPTH are pending.
- R5: A transition detected while queueFull is 1 is discarded and sets overflow. overflow stays 1 until reset, and reset clears it.
- R6: While the queue is empty, no compare takes place. In a cycle where tickEn is 1 and the counter is all ones, with the queue empty and no new transition detected, pulseOut is loaded with the synchronized input level.
- R7: Edge sensitivity flips after every detected transition, whether it was queued or discarded. After a discarded rising transition, the next falling transition is still captured and delayed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Advances the timebase counter by one when high |
| pulseIn | input | 1 | Asynchronous input waveform |
| delayVal | input | CNT_W | Delay in ticks, 1 to 2^CNT_W-1 |
| pulseOut | output | 1 | Delayed copy of the input |
| queueEmpty | output | 1 | No transition pending |
| queueFull | output | 1 | DEPTH transitions pending |
| overflow | output | 1 | Sticky: a transition was discarded |

## Verification
The assertions take for granted that delayVal is never zero and does not change while transitions are pending. They also assume the reset is applied before the first event. Under those assumptions, a retired entry always lands on a future counter value and the fill count stays bounded. The stimulus changes delayVal only after an idle stretch longer than a full counter period. Apart from the dedicated overflow run, it spaces input transitions at least a third of the delay apart, so no more than DEPTH-1 entries are ever pending.

// File: rtl/pdlPkg.sv
package pdlPkg;
  // Strobes from control to datapath, all valid in the same cycle
  typedef struct packed {
    logic push;    // enqueue the transition detected this cycle
    logic pop;     // head entry matched: drive its level and retire it
    logic resync;  // idle rollover: copy synchronized input to output
  } pdlCtrl_t;
endpackage

// File: rtl/pdlDatapath.sv
module pdlDatapath
  import pdlPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             pulseIn,
  input  logic [CNT_W-1:0] delayVal,
  input  pdlCtrl_t         ctrl,
  output logic             edgeSeen,
  output logic             headMatch,
  output logic             cntWrap,
  output logic             qEmpty,
  output logic             qFull,
  output logic             pulseOut
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam bit   POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

  // Input synchronizer and edge tracking
  logic syncA, syncB, lastLvl;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      lastLvl <= 1'b0;
    end else begin
      syncA   <= pulseIn;
      syncB   <= syncA;
      lastLvl <= syncB;  // sensitivity flips after every detected transition
    end
  end
  assign edgeSeen = syncB ^ lastLvl;

  // Free-running timebase, never cleared except by reset
  logic [CNT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rstN)       cnt <= '0;
    else if (tickEn) cnt <= cnt + 1'b1;
  end
  assign cntWrap = tickEn && (cnt == '1);

  // Circular event queue
  logic [CNT_W-1:0] targetMem [DEPTH];
  logic             levelMem  [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr, wrNext, rdNext;
  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0] captureTarget;

  assign captureTarget = cnt + delayVal;  // carry dropped by width

  generate
    if (POW2) begin : g_ptrNatural
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : g_ptrCompare
      assign wrNext = (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (ctrl.push) begin
      targetMem[wrPtr] <= captureTarget;
      levelMem[wrPtr]  <= syncB;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (ctrl.push) wrPtr <= wrNext;
      if (ctrl.pop)  rdPtr <= rdNext;
      case ({ctrl.push, ctrl.pop})
        2'b10:   fill <= fill + FILL_W'(1);
        2'b01:   fill <= fill - FILL_W'(1);
        default: fill <= fill;
      endcase
    end
  end

  assign qEmpty    = (fill == '0);
  assign qFull     = (fill == FILL_W'(DEPTH));
  assign headMatch = !qEmpty && (cnt == targetMem[rdPtr]);

  // Output stage
  always_ff @(posedge clk) begin
    if (!rstN)            pulseOut <= 1'b0;
    else if (ctrl.pop)    pulseOut <= levelMem[rdPtr];
    else if (ctrl.resync) pulseOut <= syncB;
  end

  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_W'(DEPTH));

  a_r6_pop_needs_entry: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.pop |-> !qEmpty);

  a_r2_counter_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cnt));

  a_r3_out_change_cause: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pulseOut) |-> $past(ctrl.pop || ctrl.resync));
endmodule

// File: rtl/pdlControl.sv
module pdlControl
  import pdlPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     edgeSeen,
  input  logic     headMatch,
  input  logic     cntWrap,
  input  logic     qEmpty,
  input  logic     qFull,
  output pdlCtrl_t ctrl,
  output logic     overflow
);
  always_comb begin
    ctrl.push   = edgeSeen && !qFull;
    ctrl.pop    = headMatch;
    ctrl.resync = cntWrap && qEmpty && !edgeSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  overflow <= 1'b0;
    else if (edgeSeen && qFull) overflow <= 1'b1;
  end

  a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  a_r5_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    qFull |-> !ctrl.push);

  a_r6_no_resync_pending: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.resync |-> (qEmpty && !ctrl.pop));
endmodule

// File: rtl/pulseDelayLine.sv
module pulseDelayLine
  import pdlPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             pulseIn,
  input  logic [CNT_W-1:0] delayVal,
  output logic             pulseOut,
  output logic             queueEmpty,
  output logic             queueFull,
  output logic             overflow
);
  pdlCtrl_t ctrl;
  logic edgeSeen, headMatch, cntWrap;

  pdlDatapath #(.CNT_W(CNT_W), .DEPTH(DEPTH)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .tickEn    (tickEn),
    .pulseIn   (pulseIn),
    .delayVal  (delayVal),
    .ctrl      (ctrl),
    .edgeSeen  (edgeSeen),
    .headMatch (headMatch),
    .cntWrap   (cntWrap),
    .qEmpty    (queueEmpty),
    .qFull     (queueFull),
    .pulseOut  (pulseOut)
  );

  pdlControl uControl (
    .clk       (clk),
    .rstN      (rstN),
    .edgeSeen  (edgeSeen),
    .headMatch (headMatch),
    .cntWrap   (cntWrap),
    .qEmpty    (queueEmpty),
    .qFull     (queueFull),
    .ctrl      (ctrl),
    .overflow  (overflow)
  );
endmodule

// File: tb/tb_pulseDelayLine.sv
`timescale 1ns/1ps
module tb_pulseDelayLine;
  localparam int CW = 8;
  localparam int DP = 4;

  logic clk = 1'b0;
  logic rstN, tickEn, pulseIn;
  logic [CW-1:0] delayVal;
  logic pulseOut, queueEmpty, queueFull, overflow;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int dCur = 1;
  bit chkEn = 1'b0;
  bit done = 1'b0;
  logic hist [1024];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  pulseDelayLine #(.CNT_W(CW), .DEPTH(DP)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .pulseIn(pulseIn),
    .delayVal(delayVal), .pulseOut(pulseOut), .queueEmpty(queueEmpty),
    .queueFull(queueFull), .overflow(overflow)
  );

  // History of the input as seen at each rising edge
  always @(posedge clk) begin
    hist[cyc % 1024] <= pulseIn;
    cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // R3: per-cycle comparison against the delayed input history
  always @(negedge clk) begin
    if (chkEn && !done && (cyc - 3 - dCur >= 0))
      check(pulseOut === hist[(cyc - 3 - dCur) % 1024], "R3 delayed waveform",
            int'(pulseOut), int'(hist[(cyc - 3 - dCur) % 1024]));
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitCyc(4);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic stepLfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b1; pulseIn = 1'b0; delayVal = CW'(5);
    @(negedge clk);
    doReset();
    // R1: reset state
    check(pulseOut == 1'b0, "R1 pulseOut", int'(pulseOut), 0);
    check(queueEmpty == 1'b1, "R1 queueEmpty", int'(queueEmpty), 1);
    check(queueFull == 1'b0, "R1 queueFull", int'(queueFull), 0);
    check(overflow == 1'b0, "R1 overflow", int'(overflow), 0);

    // R3/R4: sweep of delays, including 1 and the maximum, across rollover
    foreach (dList[k]) begin
      chkEn = 1'b0;
      delayVal = CW'(dList[k]);
      dCur = dList[k];
      waitCyc(300);
      chkEn = 1'b1;
      for (int e = 0; e < 12; e++) begin
        stepLfsr();
        waitCyc(dCur / 3 + 1 + int'(lfsr[1:0]));
        pulseIn = ~pulseIn;
        check(!overflow, "R4 no loss within depth", int'(overflow), 0);
      end
      waitCyc(dCur + 10);
      check(queueEmpty == 1'b1, "R4 queueEmpty after drain", int'(queueEmpty), 1);
      check(queueFull == 1'b0, "R4 queueFull after drain", int'(queueFull), 0);
    end
    if (pulseIn) begin
      chkEn = 1'b0;
      pulseIn = 1'b0;
    end

    // R5/R6/R7: overflow, sticky flag, rollover resync
    chkEn = 1'b0;
    delayVal = CW'(200);
    dCur = 200;
    waitCyc(300);
    for (int e = 0; e < 5; e++) begin
      pulseIn = ~pulseIn;
      waitCyc(4);
    end
    waitCyc(4);
    check(queueFull == 1'b1, "R4 queueFull at depth", int'(queueFull), 1);
    check(overflow == 1'b1, "R5 overflow set", int'(overflow), 1);
    waitCyc(230);
    check(queueEmpty == 1'b1, "R4 queue drained", int'(queueEmpty), 1);
    check(pulseOut == 1'b0, "R5 dropped edge not replayed", int'(pulseOut), 0);
    waitCyc(260);
    check(pulseOut == 1'b1, "R6 rollover resync", int'(pulseOut), 1);
    check(overflow == 1'b1, "R5 overflow sticky", int'(overflow), 1);
    pulseIn = 1'b0;
    waitCyc(100);
    check(queueEmpty == 1'b0, "R7 falling edge captured", int'(queueEmpty), 0);
    check(pulseOut == 1'b1, "R7 output held before delay", int'(pulseOut), 1);
    waitCyc(110);
    check(pulseOut == 1'b0, "R7 falling edge delayed", int'(pulseOut), 0);

    // R2: tick enable controls the timebase
    doReset();
    check(overflow == 1'b0, "R5 reset clears overflow", int'(overflow), 0);
    tickEn = 1'b0;
    delayVal = CW'(3);
    pulseIn = 1'b1;
    waitCyc(50);
    check(pulseOut == 1'b0, "R2 frozen counter holds output", int'(pulseOut), 0);
    check(queueEmpty == 1'b0, "R2 edge pending", int'(queueEmpty), 0);
    for (int g = 0; g < 2; g++) begin
      tickEn = 1'b1; waitCyc(1); tickEn = 1'b0; waitCyc(3);
    end
    check(pulseOut == 1'b0, "R2 two ticks not enough", int'(pulseOut), 0);
    tickEn = 1'b1; waitCyc(1); tickEn = 1'b0; waitCyc(3);
    check(pulseOut == 1'b1, "R2 third tick fires", int'(pulseOut), 1);
    check(queueEmpty == 1'b1, "R2 queue retired", int'(queueEmpty), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  int dList [9] = '{1, 2, 3, 7, 31, 100, 200, 254, 255};
endmodule